// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eight peripheral interrupt request lines and presents one interrupt output to a processor. A rising edge on a request line latches a pending request. The controller picks the most urgent pending line and raises `int_out`. A one-cycle `int_ack` pulse from the processor moves that line into service. In the next cycle the controller returns an 8-bit vector: a 5-bit programmable base followed by the 3-bit line number. Lines nest by priority. Line 0 is the most urgent and line 7 the least. A line in service blocks its own line and every less urgent line until the processor sends an end-of-interrupt pulse.

Two instances can be chained to serve 15 sources. The second instance's `int_out` drives request line 2 of the first. When `cascade_en` is set and line 2 wins an acknowledge, the first instance returns no vector. It pulses `casc_ack` instead, and that pulse serves as the second instance's acknowledge. The second instance then returns its own vector one cycle later.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `int_out`, `vec_valid` and `casc_ack` are 0, and no line is pending or in service.
- R2: A request is latched only on a 0-to-1 transition of its line. A line that stays high after its request has been serviced raises no new request.
- R3: `int_out` is 1 in the cycle after an eligible request is latched, and stays 1 while any eligible request is pending.
- R4: On an acknowledge, the lowest-numbered eligible pending line wins (line 0 is the most urgent).
- R5: An acknowledge taken while `int_out` is 1 (and the winner is not the cascade line with cascade on) gives `vec_valid` = 1 for one cycle in the next cycle. In that cycle `vec_out` = {`vec_base`[4:0], line[2:0]}, with the line number in bits 2:0.
- R6: A pending line is masked while the same line, or a lower-numbered line, is in service. A lower-numbered line can still raise `int_out` during service, so service nests.
- R7: An `eoi` pulse clears the lowest-numbered in-service line. With nothing in service it has no effect.
- R8: An `int_ack` taken while `int_out` is 0 is ignored: no `vec_valid`, no `casc_ack`, and no change of state.
- R9: With `cascade_en` = 1, a won acknowledge of line 2 puts line 2 into service and gives `casc_ack` = 1 for one cycle with `vec_valid` = 0.
- R10: After an acknowledge, `int_out` falls unless another eligible request is pending. A more urgent line latched at the same edge as the acknowledge keeps `int_out` high.
- R11: With a second instance on line 2, the second instance's vector appears on its own `vec_out`, with `vec_valid` = 1, one cycle after the first instance's `casc_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Peripheral request lines, latched on rising edge |
| vec_base | input | 5 | Upper bits of every returned vector |
| cascade_en | input | 1 | Line 2 is fed by a second instance |
| int_ack | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | `vec_out` carries a new vector this cycle |
| vec_out | output | 8 | Vector {base, line} |
| casc_ack | output | 1 | Acknowledge passed to the second instance |

## Verification
The assertions check on every cycle that:
- a granted vector carries the sampled base;
- the vector's line is the most urgent in-service line;
- an acknowledge with no request produces nothing;
- `eoi` removes exactly one in-service bit;
- a cascade pulse never comes with a vector.

Some behaviours only the bench's scenarios can show:
- priority order across mixed request patterns;
- masking of equal and less urgent lines during nested service;
- the re-enable order after successive `eoi` pulses;
- the held-level case;
- the two-instance chain with its extra cycle of vector latency.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [1:0] {
      RESP_IDLE    = 2'd0,
      RESP_VECTOR  = 2'd1,
      RESP_CASCADE = 2'd2
   } resp_e;
endpackage

// File: rtl/intc_req_latch.sv
// Edge detection and pending-request register.
module intc_req_latch #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] irq_in,
   input  logic             grant_fire,
   input  logic [LINES-1:0] grant_oh,
   output logic [LINES-1:0] pend_q
);
   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] rise;
   logic [LINES-1:0] take;

   assign rise = irq_in & ~prev_q;
   assign take = grant_fire ? grant_oh : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= irq_in;
         // a fresh edge on the granted line wins over its clear
         pend_q <= (pend_q & ~take) | rise;
      end
   end
endmodule

// File: rtl/intc_resolver.sv
// Masks pending lines by the in-service set and picks the most urgent one.
module intc_resolver #(
   parameter  int LINES = 8,
   localparam int IW    = $clog2(LINES)
) (
   input  logic [LINES-1:0] pend,
   input  logic [LINES-1:0] isr,
   output logic [LINES-1:0] elig,
   output logic [LINES-1:0] win_oh,
   output logic [IW-1:0]    win_idx
);
   always_comb begin
      logic blocked;
      blocked = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         blocked = blocked | isr[i];
         elig[i] = pend[i] & ~blocked;
      end
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      win_oh  = '0;
      win_idx = '0;
      for (int i = 0; i < LINES; i++) begin
         if (elig[i] && !found) begin
            win_oh[i] = 1'b1;
            win_idx   = IW'(i);
            found     = 1'b1;
         end
      end
   end
endmodule

// File: rtl/intc_service.sv
// In-service register: set on grant, most urgent bit cleared on eoi.
module intc_service #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_fire,
   input  logic [LINES-1:0] set_oh,
   input  logic             eoi,
   output logic [LINES-1:0] isr_q
);
   logic [LINES-1:0] clr_oh;

   always_comb begin
      logic found;
      found  = 1'b0;
      clr_oh = '0;
      for (int i = 0; i < LINES; i++) begin
         if (isr_q[i] && !found) begin
            clr_oh[i] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
      end else begin
         isr_q <= (isr_q & ~(eoi ? clr_oh : '0)) | (set_fire ? set_oh : '0);
      end
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import intc_pkg::*;
#(
   parameter  int NUM_LINES    = 8,
   parameter  int BASE_W       = 5,
   parameter  int CASCADE_LINE = 2,
   localparam int IDX_W        = $clog2(NUM_LINES),
   localparam int VEC_W        = BASE_W + IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req,
   input  logic [BASE_W-1:0]    vec_base,
   input  logic                 cascade_en,
   input  logic                 int_ack,
   input  logic                 eoi,
   output logic                 int_out,
   output logic                 vec_valid,
   output logic [VEC_W-1:0]     vec_out,
   output logic                 casc_ack
);
   generate
      if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
         $error("NUM_LINES must be a power of two, at least 2");
      end
      if (CASCADE_LINE < 0 || CASCADE_LINE >= NUM_LINES) begin : g_bad_casc
         $error("CASCADE_LINE must name an existing line");
      end
      if (BASE_W < 1) begin : g_bad_base
         $error("BASE_W must be at least 1");
      end
   endgenerate

   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] isr_q;
   logic [NUM_LINES-1:0] elig;
   logic [NUM_LINES-1:0] win_oh;
   logic [IDX_W-1:0]     win_idx;
   logic                 grant_fire;
   logic                 to_slave;
   resp_e                resp_q;
   logic [VEC_W-1:0]     vec_q;

   intc_req_latch #(.LINES(NUM_LINES)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_req),
      .grant_fire(grant_fire), .grant_oh(win_oh), .pend_q(pend_q)
   );

   intc_resolver #(.LINES(NUM_LINES)) u_res (
      .pend(pend_q), .isr(isr_q), .elig(elig),
      .win_oh(win_oh), .win_idx(win_idx)
   );

   intc_service #(.LINES(NUM_LINES)) u_svc (
      .clk(clk), .rst_n(rst_n), .set_fire(grant_fire),
      .set_oh(win_oh), .eoi(eoi), .isr_q(isr_q)
   );

   assign int_out    = |elig;
   assign grant_fire = int_ack & int_out;
   assign to_slave   = cascade_en && (win_idx == IDX_W'(CASCADE_LINE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_q <= RESP_IDLE;
         vec_q  <= '0;
      end else if (grant_fire) begin
         if (to_slave) begin
            resp_q <= RESP_CASCADE;
         end else begin
            resp_q <= RESP_VECTOR;
            vec_q  <= {vec_base, win_idx};
         end
      end else begin
         resp_q <= RESP_IDLE;
      end
   end

   assign vec_valid = (resp_q == RESP_VECTOR);
   assign casc_ack  = (resp_q == RESP_CASCADE);
   assign vec_out   = vec_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int LINES = 8,
   parameter int IW    = 3,
   parameter int VW    = 8,
   parameter int CASC  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             int_ack,
   input logic             eoi,
   input logic             cascade_en,
   input logic [VW-IW-1:0] vec_base,
   input logic             int_out,
   input logic             vec_valid,
   input logic [VW-1:0]    vec_out,
   input logic             casc_ack,
   input logic [LINES-1:0] pend,
   input logic [LINES-1:0] isr
);
   logic [LINES-1:0] below;
   assign below = (LINES'(1) << vec_out[IW-1:0]) - LINES'(1);

   assert_out_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (pend != '0));

   assert_vector_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out && !cascade_en) |=> (vec_valid && vec_out[VW-1:IW] == $past(vec_base)));

   // R4 and R6: the returned line is the most urgent one in service
   assert_vector_is_top_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (isr[vec_out[IW-1:0]] && ((isr & below) == '0)));

   assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !int_out) |=> (!vec_valid && !casc_ack));

   assert_eoi_clears_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !(int_ack && int_out) && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

   assert_cascade_no_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
      casc_ack |-> (!vec_valid && isr[CASC] && $past(cascade_en)));
endmodule

bind prio_vec_intc intc_chk #(
   .LINES(NUM_LINES), .IW(IDX_W), .VW(VEC_W), .CASC(CASCADE_LINE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .eoi(eoi),
   .cascade_en(cascade_en), .vec_base(vec_base), .int_out(int_out),
   .vec_valid(vec_valid), .vec_out(vec_out), .casc_ack(casc_ack),
   .pend(pend_q), .isr(isr_q)
);

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
   localparam int CLK_PERIOD = 10;

   // entry: {request pattern[7:0], base[4:0], expected winning line[2:0]}
   localparam logic [15:0] TBL [6] = '{
      {8'b1000_0000, 5'h03, 3'd7},
      {8'b0110_0100, 5'h11, 3'd2},
      {8'b1111_1111, 5'h1f, 3'd0},
      {8'b1010_1000, 5'h08, 3'd3},
      {8'b0001_0010, 5'h15, 3'd1},
      {8'b1100_0000, 5'h0a, 3'd6}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] m_irq = '0;
   logic [4:0] m_base = '0;
   logic       m_casc = 1'b0;
   logic       m_ack = 1'b0;
   logic       m_eoi = 1'b0;
   logic       m_int, m_vv, m_cack;
   logic [7:0] m_vec;
   logic [7:0] m_irq_full;

   logic [7:0] s_irq = '0;
   logic [4:0] s_base = '0;
   logic       s_eoi = 1'b0;
   logic       s_int, s_vv, s_cack;
   logic [7:0] s_vec;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign m_irq_full = {m_irq[7:3], m_casc ? s_int : m_irq[2], m_irq[1:0]};

   prio_vec_intc i_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .irq_req(m_irq_full), .vec_base(m_base),
      .cascade_en(m_casc), .int_ack(m_ack), .eoi(m_eoi),
      .int_out(m_int), .vec_valid(m_vv), .vec_out(m_vec), .casc_ack(m_cack)
   );

   prio_vec_intc i_slave (
      .clk(clk), .rst_n(rst_n), .irq_req(s_irq), .vec_base(s_base),
      .cascade_en(1'b0), .int_ack(m_cack), .eoi(s_eoi),
      .int_out(s_int), .vec_valid(s_vv), .vec_out(s_vec), .casc_ack(s_cack)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; m_irq = '0; s_irq = '0; m_ack = 0; m_eoi = 0; s_eoi = 0; m_casc = 0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic ack_pulse();
      m_ack = 1'b1; tick(); m_ack = 1'b0;
   endtask

   task automatic eoi_pulse();
      m_eoi = 1'b1; tick(); m_eoi = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 int_out after reset", m_int, 0);
      chk("R1 vec_valid after reset", m_vv, 0);
      chk("R1 casc_ack after reset", m_cack, 0);

      // table of patterns, one reset per entry
      for (int k = 0; k < 6; k++) begin
         logic [15:0] e;
         e = TBL[k];
         do_reset();
         m_base = e[7:3];
         m_irq  = e[15:8];
         tick();
         chk("R3 int_out raised by pattern", m_int, 1);
         ack_pulse();
         chk("R5 vec_valid after ack", m_vv, 1);
         chk("R4 winning vector", m_vec, {e[7:3], e[2:0]});
         chk("R10 int_out falls, rest masked", m_int, 0);
         m_irq = '0;
      end

      // nesting and end-of-interrupt order
      do_reset();
      m_base = 5'h02;
      m_irq[4] = 1; tick();
      ack_pulse();
      chk("R5 line 4 vector", m_vec, {5'h02, 3'd4});
      m_irq[6] = 1; tick();
      chk("R6 less urgent line masked", m_int, 0);
      m_irq[4] = 0; tick(); m_irq[4] = 1; tick();
      chk("R6 same line masked while in service", m_int, 0);
      m_irq[1] = 1; tick();
      chk("R6 more urgent line nests", m_int, 1);
      ack_pulse();
      chk("R4 nested vector line 1", m_vec, {5'h02, 3'd1});
      chk("R10 int_out low after nested ack", m_int, 0);
      eoi_pulse();
      chk("R7 eoi clears line 1 only, line 4 still masks", m_int, 0);
      eoi_pulse();
      chk("R7 eoi clears line 4, pending 4 eligible", m_int, 1);
      ack_pulse();
      chk("R4 second line 4 vector", m_vec, {5'h02, 3'd4});
      eoi_pulse();
      chk("R7 line 6 eligible after eoi", m_int, 1);
      ack_pulse();
      chk("R4 line 6 vector", m_vec, {5'h02, 3'd6});
      eoi_pulse();
      tick();
      chk("R2 held levels raise nothing", m_int, 0);

      // acknowledge with nothing pending
      do_reset();
      m_base = 5'h07;
      ack_pulse();
      chk("R8 no vector on stray ack", m_vv, 0);
      chk("R8 no cascade on stray ack", m_cack, 0);
      chk("R8 int_out stays low", m_int, 0);
      m_irq[3] = 1; tick();
      ack_pulse();
      chk("R8 state unchanged, line 3 served", m_vec, {5'h07, 3'd3});

      // eoi with empty service set
      do_reset();
      m_base = 5'h1c;
      eoi_pulse();
      m_irq[7] = 1; tick();
      chk("R7 empty eoi harmless", m_int, 1);
      ack_pulse();
      chk("R7 line 7 vector after empty eoi", m_vec, {5'h1c, 3'd7});

      // more urgent request at the same edge as the acknowledge
      do_reset();
      m_base = 5'h05;
      m_irq[3] = 1; tick();
      m_ack = 1; m_irq[0] = 1; tick(); m_ack = 0;
      chk("R4 line 3 granted", m_vec, {5'h05, 3'd3});
      chk("R10 int_out held by new line 0", m_int, 1);
      ack_pulse();
      chk("R4 line 0 granted", m_vec, {5'h05, 3'd0});

      // cascade through line 2
      do_reset();
      m_casc = 1; m_base = 5'h04; s_base = 5'h19;
      s_irq[5] = 1; tick();
      chk("R11 slave int_out", s_int, 1);
      tick();
      chk("R11 master sees slave request", m_int, 1);
      ack_pulse();
      chk("R9 cascade pulse", m_cack, 1);
      chk("R9 no master vector", m_vv, 0);
      tick();
      chk("R11 slave vector valid", s_vv, 1);
      chk("R11 slave vector", s_vec, {5'h19, 3'd5});
      chk("R9 cascade pulse one cycle", m_cack, 0);
      chk("R10 master int_out low", m_int, 0);
      m_irq[0] = 1; tick();
      chk("R6 line 0 nests over cascade", m_int, 1);
      ack_pulse();
      chk("R9 ordinary line still vectored", m_vv, 1);
      chk("R5 master vector line 0", m_vec, {5'h04, 3'd0});

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule